// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block sits between a processor core and a byte-wide program memory. When the core asks for the next instruction, the sequencer reads one opcode byte. It works out from the opcode how many immediate bytes follow: none, one or two. It then reads those bytes from the addresses that come next and hands the core one assembled result. The result holds the opcode, its format class, an 8-bit immediate, a 16-bit immediate word and the address of the following instruction.

The core uses a start/ready handshake. `ready` is high while the sequencer is idle and its outputs hold the last instruction. Pulsing `start` begins a new fetch. The memory side is a request/valid read port that may stall for any number of cycles. A jump, call or return redirects the sequencer by loading a new program counter through `load_pc` while it is idle. Decoding into datapath controls and data-side memory accesses belong to other blocks.

Top module: `fetch_sequencer`

## Requirements
- R1: After reset the program counter (`next_pc`) is RESET_PC (0x0000), `ready` is 1, `mem_req` is 0, and `opcode`, `fmt`, `imm_byte` and `imm_word` are all 0. The block makes no memory request until `start` is seen.
- R2: When `start` is 1 while `ready` is 1, the next cycle drops `ready` and raises `mem_req` with `mem_addr` equal to the program counter, to read the opcode byte.
- R3: The format class is opcode bits [7:5]. Classes 0 (bare), 1 (one register) and 2 (two registers) carry no immediate byte. Classes 3 (8-bit immediate) and 4 (register plus 8-bit immediate) carry one. Classes 5 (16-bit immediate), 6 (register plus 16-bit immediate) and 7 (memory reference) carry two. Exactly 1 plus that count bytes are read, and `ready` returns to 1 the cycle after the last byte is accepted.
- R4: Immediate bytes are read at consecutive addresses after the opcode. For two-byte classes the first byte read becomes `imm_word[15:8]` and the second becomes `imm_word[7:0]`.
- R5: For one-byte classes `imm_byte` holds the byte and `imm_word` is that byte zero-extended. For two-byte classes `imm_byte` is 0. For classes without an immediate, both are 0.
- R6: When `ready` returns, `next_pc` equals the opcode address plus 1 plus the immediate count, modulo 2^16.
- R7: While `mem_req` is 1 and `mem_valid` is 0, the next cycle keeps `mem_req` high and `mem_addr` unchanged.
- R8: `load_pc` while `ready` is 1 loads `load_addr` into the program counter. If `start` comes in the same cycle, the opcode is read from `load_addr`.
- R9: `load_pc` while `ready` is 0 is ignored: the fetch continues at sequential addresses and `next_pc` ends as if no load had been requested.
- R10: While `ready` is 1 and `start` is 0, `ready` stays 1 and the result outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin fetching one instruction (taken when ready) |
| ready | output | 1 | Idle; result outputs valid |
| load_pc | input | 1 | Load program counter (honoured only when ready) |
| load_addr | input | ADDR_W | New program counter value |
| mem_req | output | 1 | Program memory read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_data | input | 8 | Read data, qualified by mem_valid |
| mem_valid | input | 1 | Read data valid this cycle; the byte is taken |
| opcode | output | 8 | Fetched opcode byte |
| fmt | output | 3 | Format class of the opcode |
| imm_byte | output | 8 | One-byte immediate, else 0 |
| imm_word | output | 16 | Assembled immediate word, high byte first |
| next_pc | output | ADDR_W | Program counter, address of the next opcode |

## Verification
The bench builds the block with its default parameters: a 16-bit program counter and a reset value of 0x0000. The full 16-bit width lets a two-byte instruction placed at 0xFFFE read its low byte from 0x0000 and leave `next_pc` at 0x0001, which tests the wrap. The reset value of zero lets the first table entry start fetching with no prior load. The bench's 256-byte program image repeats every 256 addresses, so the same image serves both the low region and the wrap case.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int FMT_W   = 3;
    localparam int FMT_LSB = BYTE_W - FMT_W;

    typedef enum logic [FMT_W-1:0] {
        FMT_BARE      = 3'd0,
        FMT_ONEREG    = 3'd1,
        FMT_TWOREG    = 3'd2,
        FMT_IMM8      = 3'd3,
        FMT_REG_IMM8  = 3'd4,
        FMT_IMM16     = 3'd5,
        FMT_REG_IMM16 = 3'd6,
        FMT_MEMREF    = 3'd7
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPC   = 2'd1,
        ST_IMM_A = 2'd2,
        ST_IMM_B = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] opcode;
        fmt_e              fmt;
        logic [BYTE_W-1:0] imm_byte;
        logic [WORD_W-1:0] imm_word;
    } fetch_result_t;

    // Format class lives in the top bits of the opcode byte.
    function automatic fmt_e fmt_of(input logic [BYTE_W-1:0] op);
        return fmt_e'(op[BYTE_W-1:FMT_LSB]);
    endfunction

    // Number of immediate bytes that follow an opcode of class f.
    function automatic logic [1:0] imm_bytes_of(input fmt_e f);
        logic [1:0] n;
        if (f == FMT_IMM8 || f == FMT_REG_IMM8)
            n = 2'd1;
        else if (f == FMT_IMM16 || f == FMT_REG_IMM16 || f == FMT_MEMREF)
            n = 2'd2;
        else
            n = 2'd0;
        return n;
    endfunction

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mem_valid,
    input  logic [BYTE_W-1:0] mem_data,
    output seq_state_e        state,
    output logic              ready,
    output logic              mem_req,
    output logic              take
);

    seq_state_e state_q;
    logic       wide_q;
    logic [1:0] opc_imm_n;

    assign opc_imm_n = imm_bytes_of(fmt_of(mem_data));
    assign state     = state_q;
    assign ready     = (state_q == ST_IDLE);
    assign mem_req   = (state_q != ST_IDLE);
    assign take      = mem_req && mem_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wide_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) state_q <= ST_OPC;
                end
                ST_OPC: begin
                    if (mem_valid) begin
                        if (opc_imm_n == 2'd0) begin
                            state_q <= ST_IDLE;
                        end else begin
                            wide_q  <= (opc_imm_n == 2'd2);
                            state_q <= ST_IMM_A;
                        end
                    end
                end
                ST_IMM_A: begin
                    if (mem_valid) state_q <= wide_q ? ST_IMM_B : ST_IDLE;
                end
                ST_IMM_B: begin
                    if (mem_valid) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> (!ready && mem_req));

    assert_short_done_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPC && mem_valid && opc_imm_n == 2'd0) |=> ready);

    assert_long_continue_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPC && mem_valid && opc_imm_n != 2'd0) |=> (state_q == ST_IMM_A));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> ready);

endmodule

// File: rtl/fseq_pc.sv
module fseq_pc #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ready,
    input  logic              load_pc,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;
    assign pc = pc_q;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_PC;
        else if (ready && load_pc)
            pc_q <= load_addr;
        else if (step)
            pc_q <= pc_q + ONE;
    end

    assert_reset_pc_R1: assert property (@(posedge clk)
        rst |=> (pc_q == RESET_PC));

    assert_step_incr_R6: assert property (@(posedge clk) disable iff (rst)
        step |=> (pc_q == $past(pc_q) + ONE));

    assert_idle_load_R8: assert property (@(posedge clk) disable iff (rst)
        (ready && load_pc) |=> (pc_q == $past(load_addr)));

    assert_busy_load_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (!ready && load_pc && !step) |=> $stable(pc_q));

endmodule

// File: rtl/fseq_imm.sv
module fseq_imm
    import fseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic              mem_valid,
    input  logic [BYTE_W-1:0] mem_data,
    output fetch_result_t     res
);

    fetch_result_t res_q;
    logic          wide;

    assign res  = res_q;
    assign wide = (imm_bytes_of(res_q.fmt) == 2'd2);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (mem_valid) begin
            case (state)
                ST_OPC: begin
                    res_q.opcode   <= mem_data;
                    res_q.fmt      <= fmt_of(mem_data);
                    res_q.imm_byte <= '0;
                    res_q.imm_word <= '0;
                end
                ST_IMM_A: begin
                    if (wide) begin
                        res_q.imm_word[WORD_W-1:BYTE_W] <= mem_data;
                    end else begin
                        res_q.imm_byte <= mem_data;
                        res_q.imm_word <= {{(WORD_W-BYTE_W){1'b0}}, mem_data};
                    end
                end
                ST_IMM_B: begin
                    res_q.imm_word[BYTE_W-1:0] <= mem_data;
                end
                default: ;
            endcase
        end
    end

    assert_wide_no_byte_R5: assert property (@(posedge clk) disable iff (rst)
        wide |-> (res_q.imm_byte == '0));

    assert_narrow_zero_ext_R5: assert property (@(posedge clk) disable iff (rst)
        !wide |-> (res_q.imm_word[WORD_W-1:BYTE_W] == '0));

    assert_opcode_class_R3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_OPC) |=> (res_q.fmt == fmt_of(res_q.opcode)));

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
    import fseq_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              ready,
    input  logic              load_pc,
    input  logic [ADDR_W-1:0] load_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data,
    input  logic              mem_valid,
    output logic [7:0]        opcode,
    output logic [2:0]        fmt,
    output logic [7:0]        imm_byte,
    output logic [15:0]       imm_word,
    output logic [ADDR_W-1:0] next_pc
);

    seq_state_e        state;
    logic              take;
    logic [ADDR_W-1:0] pc;
    fetch_result_t     res;

    fseq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mem_valid (mem_valid),
        .mem_data  (mem_data),
        .state     (state),
        .ready     (ready),
        .mem_req   (mem_req),
        .take      (take)
    );

    fseq_pc #(
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk       (clk),
        .rst       (rst),
        .ready     (ready),
        .load_pc   (load_pc),
        .load_addr (load_addr),
        .step      (take),
        .pc        (pc)
    );

    fseq_imm u_imm (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .mem_valid (mem_valid),
        .mem_data  (mem_data),
        .res       (res)
    );

    assign mem_addr = pc;
    assign next_pc  = pc;
    assign opcode   = res.opcode;
    assign fmt      = res.fmt;
    assign imm_byte = res.imm_byte;
    assign imm_word = res.imm_word;

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> !mem_req);

endmodule

// File: tb/fetch_sequencer_bench.sv
`timescale 1ns/1ps
module fetch_sequencer_bench;

    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              ready;
    logic              load_pc = 1'b0;
    logic [ADDR_W-1:0] load_addr = '0;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_data;
    logic              mem_valid = 1'b0;
    logic [7:0]        opcode;
    logic [2:0]        fmt;
    logic [7:0]        imm_byte;
    logic [15:0]       imm_word;
    logic [ADDR_W-1:0] next_pc;

    always #2.5 clk = ~clk;

    fetch_sequencer #(.ADDR_W(ADDR_W)) u_fetch_sequencer (
        .clk(clk), .rst(rst), .start(start), .ready(ready),
        .load_pc(load_pc), .load_addr(load_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_valid(mem_valid), .opcode(opcode), .fmt(fmt),
        .imm_byte(imm_byte), .imm_word(imm_word), .next_pc(next_pc)
    );

    logic [7:0] prog [256];
    assign mem_data = prog[mem_addr[7:0]];

    int n_checks = 0;
    int n_fail   = 0;
    int stall_len = 0;
    int taken;

    // stall[63:56] opcode[55:48] fmt[47:40] imm_byte[39:32] imm_word[31:16] next_pc[15:0]
    localparam logic [63:0] VEC [8] = '{
        64'h00_05_00_00_0000_0001,
        64'h02_3A_01_00_0000_0002,
        64'h01_47_02_00_0000_0003,
        64'h03_61_03_9C_009C_0005,
        64'h00_88_04_03_0003_0007,
        64'h04_A0_05_00_1234_000A,
        64'h01_C5_06_00_BEEF_000D,
        64'h02_E2_07_00_8001_0010
    };

    function automatic int imm_count(input logic [2:0] f);
        if (f == 3'd3 || f == 3'd4) return 1;
        if (f >= 3'd5) return 2;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: request seen just after each edge, valid raised after stall_len cycles per address.
    initial begin
        logic              have_last;
        logic [ADDR_W-1:0] last_addr;
        int                cnt;
        have_last = 1'b0; last_addr = '0; cnt = 0;
        forever begin
            @(posedge clk);
            #1;
            if (!mem_req) begin
                mem_valid = 1'b0;
                have_last = 1'b0;
            end else begin
                if (!have_last || mem_addr != last_addr) begin
                    have_last = 1'b1;
                    last_addr = mem_addr;
                    cnt = stall_len;
                end
                if (cnt > 0) begin
                    cnt--;
                    mem_valid = 1'b0;
                end else begin
                    mem_valid = 1'b1;
                end
            end
        end
    end

    // Issue one instruction fetch; checks addresses (R4) and stall holding (R7).
    task automatic issue(input bit ld, input logic [15:0] la, input int st,
                         input logic [15:0] first, input bit busy_load);
        int          k;
        int          guard;
        bit          prev_stall;
        logic [15:0] prev_addr;
        stall_len = st;
        @(negedge clk);
        start = 1'b1; load_pc = ld; load_addr = la;
        @(negedge clk);
        start = 1'b0;
        load_pc = busy_load;
        if (busy_load) load_addr = 16'h0003;
        chk(!ready && mem_req, "R2 busy after start", {30'd0, ready, mem_req}, 32'h1);
        chk(mem_addr == first, "R2 opcode address", mem_addr, first);
        k = 0; guard = 0; prev_stall = 1'b0; prev_addr = '0;
        while (!ready && guard < 200) begin
            if (prev_stall)
                chk(mem_req && mem_addr == prev_addr, "R7 stall hold", mem_addr, prev_addr);
            if (mem_req && mem_valid) begin
                chk(mem_addr == 16'(first + k), "R4 sequential address", mem_addr, 16'(first + k));
                k++;
            end
            prev_stall = mem_req && !mem_valid;
            prev_addr  = mem_addr;
            guard++;
            @(negedge clk);
        end
        if (guard >= 200) chk(1'b0, "R3 fetch hung", guard, 0);
        load_pc = 1'b0;
        taken = k;
    endtask

    task automatic expect_result(input string tag, input logic [7:0] e_op, input logic [2:0] e_fmt,
                                 input logic [7:0] e_ib, input logic [15:0] e_iw, input logic [15:0] e_np);
        chk(opcode == e_op, {tag, " R3 opcode"}, opcode, e_op);
        chk(fmt == e_fmt, {tag, " R3 format"}, fmt, e_fmt);
        chk(taken == 1 + imm_count(e_fmt), {tag, " R3 byte count"}, taken, 1 + imm_count(e_fmt));
        chk(imm_byte == e_ib, {tag, " R5 imm_byte"}, imm_byte, e_ib);
        chk(imm_word == e_iw, {tag, " R4 imm_word"}, imm_word, e_iw);
        chk(next_pc == e_np, {tag, " R6 next_pc"}, next_pc, e_np);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        prog[8'h00] = 8'h05; prog[8'h01] = 8'h3A; prog[8'h02] = 8'h47;
        prog[8'h03] = 8'h61; prog[8'h04] = 8'h9C;
        prog[8'h05] = 8'h88; prog[8'h06] = 8'h03;
        prog[8'h07] = 8'hA0; prog[8'h08] = 8'h12; prog[8'h09] = 8'h34;
        prog[8'h0A] = 8'hC5; prog[8'h0B] = 8'hBE; prog[8'h0C] = 8'hEF;
        prog[8'h0D] = 8'hE2; prog[8'h0E] = 8'h80; prog[8'h0F] = 8'h01;
        prog[8'hFE] = 8'hF1; prog[8'hFF] = 8'hAB;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1 ready after reset", ready, 1);
        chk(mem_req == 1'b0, "R1 no request after reset", mem_req, 0);
        chk(next_pc == 16'h0000, "R1 reset pc", next_pc, 0);
        chk(opcode == 0 && fmt == 0 && imm_byte == 0 && imm_word == 0, "R1 outputs zero",
            {opcode, 5'd0, fmt, imm_byte, 8'd0}, 0);
        begin
            bit quiet;
            quiet = 1'b1;
            for (int c = 0; c < 5; c++) begin
                @(negedge clk);
                if (mem_req || !ready) quiet = 1'b0;
            end
            chk(quiet, "R1 idle until start", quiet, 1);
            chk(next_pc == 16'h0000, "R10 pc held while idle", next_pc, 0);
        end

        // Table walk through all eight format classes
        begin
            logic [15:0] pc_exp;
            pc_exp = 16'h0000;
            for (int v = 0; v < 8; v++) begin
                issue(1'b0, 16'h0, int'(VEC[v][63:56]), pc_exp, 1'b0);
                expect_result($sformatf("vec%0d", v), VEC[v][55:48], VEC[v][42:40],
                              VEC[v][39:32], VEC[v][31:16], VEC[v][15:0]);
                pc_exp = VEC[v][15:0];
            end
        end

        // R10: outputs held while idle
        repeat (3) @(negedge clk);
        chk(ready && opcode == 8'hE2 && imm_word == 16'h8001, "R10 result held", imm_word, 16'h8001);

        // R8 and R6: load with start, wrap past 0xFFFF
        issue(1'b1, 16'hFFFE, 1, 16'hFFFE, 1'b0);
        expect_result("wrap", 8'hF1, 3'd7, 8'h00, 16'hAB05, 16'h0001);

        // R8: load while idle without start, then start later
        @(negedge clk);
        load_pc = 1'b1; load_addr = 16'h0003;
        @(negedge clk);
        load_pc = 1'b0;
        chk(next_pc == 16'h0003, "R8 idle load", next_pc, 16'h0003);
        chk(mem_req == 1'b0, "R8 load makes no request", mem_req, 0);
        @(negedge clk);
        issue(1'b0, 16'h0, 0, 16'h0003, 1'b0);
        expect_result("idleload", 8'h61, 3'd3, 8'h9C, 16'h009C, 16'h0005);

        // R9: load requested during a stalled fetch is ignored
        issue(1'b1, 16'h0007, 3, 16'h0007, 1'b1);
        expect_result("busyload R9", 8'hA0, 3'd5, 8'h00, 16'h1234, 16'h000A);
        issue(1'b0, 16'h0, 0, 16'h000A, 1'b0);
        expect_result("after R9", 8'hC5, 3'd6, 8'h00, 16'hBEEF, 16'h000D);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule